// File: doc/BRIEF.md
# Receive Overflow FIFO with Bypass

This block sits in the receiving clock domain of a mesochronous crossing. Each cycle, the forward cyclic buffer hands it the word and the valid bit picked by the free-running read pointer. The receiver's accept signal decides what happens to that word. Because the read pointer never stops, any word that arrives while the receiver is stalled would be lost. The block stores those words in a small single-clock FIFO. When the FIFO holds nothing, an arriving word goes to the output in the same cycle, so the normal path adds no latency.

The block also computes the flow-control token that is written back into the backward buffer at the read pointer. The token is 1 (clear to send) or 0 (do not send). It comes directly from the FIFO occupancy, so the block has no separate full flag.

The FIFO depth is `max(BURST_LEN, XFER_STAGES) + WIRE_CYC`. `XFER_STAGES` is the forward buffer depth, four by default, and `WIRE_CYC` is the link delay in cycles. The occupancy threshold sits `XFER_STAGES + WIRE_CYC` words below the depth. With the default parameters the depth is 8 and the threshold is 4.

Top module: `rx_ovf_bypass`

## Requirements
- R1: After a synchronous reset the FIFO is empty. With `rd_word_vld`=0 and `rcv_pop`=0, the block then shows `out_empty`=1 and `bk_token`=1.
- R2: When the FIFO is empty and `rd_word_vld`=1, `out_word` equals `rd_word` in the same cycle. If `rcv_pop`=1 in that cycle, the word is consumed and is not stored.
- R3: Suppose the sender writes only into forward stages whose token is 1, with the worst-case token round trip of the forward buffer depth. Then the FIFO never has to accept a word while it holds `DEPTH` words.
- R4: When the FIFO is not empty, `out_word` is the oldest stored word.
- R5: `out_empty` is 0 when the FIFO holds data, or when it is empty and `rd_word_vld`=1. Otherwise `out_empty` is 1.
- R6: In any cycle with `rcv_pop`=1, `bk_token` is 1.
- R7: In a cycle with `rcv_pop`=0, `bk_token` is 0 if the stored count is at least the threshold (4 by default), and 1 otherwise.
- R8: A word presented with `rd_word_vld`=0 is never stored, whatever its data.
- R9: Words leave in arrival order. With `rcv_pop`=1, a non-empty FIFO and a valid incoming word, the head is popped and the new word is pushed in the same cycle, so the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_word | input | WIDTH | Word selected from the forward buffer by the read pointer |
| rd_word_vld | input | 1 | Valid bit of that word |
| rcv_pop | input | 1 | Receiver accepts a word this cycle |
| out_word | output | WIDTH | Word offered to the receiver |
| out_empty | output | 1 | No word is available this cycle |
| bk_token | output | 1 | Token to write into the backward buffer stage at the read pointer |

## Verification
The assertions check these rules on every cycle:
- the token is 1 whenever the receiver accepts;
- the token is 0 when the receiver stalls at or above the threshold;
- the empty flag follows the occupancy and the incoming valid bit;
- the bypass path forwards the incoming word unchanged;
- an invalid word never raises the count;
- a same-cycle push and pop leaves the count unchanged;
- the FIFO never receives a push while full.

Other properties show only in the bench's scenarios, where a model of the forward and backward cyclic buffers closes the token loop. These are exact word ordering across continuous, random, long-stall and sparse-sender patterns, the absence of loss when tokens arrive late, and the rejection of garbage carried by invalid words.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic [2:0] {
        ACT_IDLE   = 3'd0,
        ACT_BYPASS = 3'd1,
        ACT_PUSH   = 3'd2,
        ACT_POP    = 3'd3,
        ACT_SWAP   = 3'd4
    } ovf_act_e;

    function automatic int ovf_depth(input int burst_len, input int stages, input int wire_cyc);
        int base;
        base = (burst_len > stages) ? burst_len : stages;
        return base + wire_cyc;
    endfunction

    function automatic int ovf_thresh(input int depth, input int stages, input int wire_cyc);
        return depth - stages - wire_cyc;
    endfunction

    function automatic logic act_pushes(input ovf_act_e a);
        return (a == ACT_PUSH) || (a == ACT_SWAP);
    endfunction

    function automatic logic act_pops(input ovf_act_e a);
        return (a == ACT_POP) || (a == ACT_SWAP);
    endfunction

endpackage

// File: rtl/ovf_ctrl.sv
module ovf_ctrl
    import ovf_pkg::*;
(
    input  logic     word_vld,
    input  logic     accept,
    input  logic     store_empty,
    input  logic     above_thresh,
    output ovf_act_e act,
    output logic     token
);

    always_comb begin
        act = ACT_IDLE;
        if (accept) begin
            if (store_empty) begin
                act = word_vld ? ACT_BYPASS : ACT_IDLE;
            end else begin
                act = word_vld ? ACT_SWAP : ACT_POP;
            end
        end else if (word_vld) begin
            act = ACT_PUSH;
        end
    end

    always_comb begin
        token = accept ? 1'b1 : ~above_thresh;
    end

endmodule

// File: rtl/ovf_store.sv
module ovf_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int THRESH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    fill,
    output logic             is_empty,
    output logic             at_thresh
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] THRESH_C = CW'(THRESH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    fill_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({wr_en, rd_en})
                2'b10:   fill_q <= fill_q + CW'(1);
                2'b01:   fill_q <= fill_q - CW'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end

    assign head      = mem[rd_ptr];
    assign fill      = fill_q;
    assign is_empty  = (fill_q == '0);
    assign at_thresh = (fill_q >= THRESH_C);

endmodule

// File: rtl/ovf_outsel.sv
module ovf_outsel #(
    parameter int WIDTH = 8
) (
    input  logic             store_empty,
    input  logic [WIDTH-1:0] head,
    input  logic [WIDTH-1:0] word,
    input  logic             word_vld,
    output logic [WIDTH-1:0] sel_word,
    output logic             none_avail
);

    always_comb begin
        if (store_empty) begin
            sel_word   = word;
            none_avail = ~word_vld;
        end else begin
            sel_word   = head;
            none_avail = 1'b0;
        end
    end

endmodule

// File: rtl/rx_ovf_bypass.sv
module rx_ovf_bypass
    import ovf_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int XFER_STAGES = 4,
    parameter int BURST_LEN   = 8,
    parameter int WIRE_CYC    = 0,
    localparam int DEPTH  = ovf_depth(BURST_LEN, XFER_STAGES, WIRE_CYC),
    localparam int THRESH = ovf_thresh(DEPTH, XFER_STAGES, WIRE_CYC),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rd_word,
    input  logic             rd_word_vld,
    input  logic             rcv_pop,
    output logic [WIDTH-1:0] out_word,
    output logic             out_empty,
    output logic             bk_token
);

    ovf_act_e         act;
    logic             push_en;
    logic             pop_en;
    logic [WIDTH-1:0] head_word;
    logic [CW-1:0]    fill_cnt;
    logic             st_empty;
    logic             st_thresh;

    ovf_ctrl ctrl_i (
        .word_vld    (rd_word_vld),
        .accept      (rcv_pop),
        .store_empty (st_empty),
        .above_thresh(st_thresh),
        .act         (act),
        .token       (bk_token)
    );

    assign push_en = act_pushes(act);
    assign pop_en  = act_pops(act);

    ovf_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .THRESH(THRESH)
    ) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (push_en),
        .rd_en    (pop_en),
        .wr_data  (rd_word),
        .head     (head_word),
        .fill     (fill_cnt),
        .is_empty (st_empty),
        .at_thresh(st_thresh)
    );

    ovf_outsel #(
        .WIDTH(WIDTH)
    ) outsel_i (
        .store_empty(st_empty),
        .head       (head_word),
        .word       (rd_word),
        .word_vld   (rd_word_vld),
        .sel_word   (out_word),
        .none_avail (out_empty)
    );

endmodule

// File: rtl/rx_ovf_bypass_chk.sv
module rx_ovf_bypass_chk #(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4,
    parameter int CW     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] rd_word,
    input logic             rd_word_vld,
    input logic             rcv_pop,
    input logic [WIDTH-1:0] out_word,
    input logic             out_empty,
    input logic             bk_token,
    input logic [CW-1:0]    fill_cnt,
    input logic             push_en,
    input logic             pop_en
);

    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
    localparam logic [CW-1:0] THRESH_C = CW'(THRESH);

    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == DEPTH_C) |-> !(push_en && !pop_en));

    // R3
    a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= DEPTH_C);

    // R6
    a_r6_token_on_accept: assert property (@(posedge clk) disable iff (rst)
        rcv_pop |-> bk_token);

    // R7
    a_r7_token_stall_high: assert property (@(posedge clk) disable iff (rst)
        (!rcv_pop && fill_cnt >= THRESH_C) |-> !bk_token);

    // R7
    a_r7_token_stall_low: assert property (@(posedge clk) disable iff (rst)
        (!rcv_pop && fill_cnt < THRESH_C) |-> bk_token);

    // R5
    a_r5_empty_stored: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt != '0) |-> !out_empty);

    // R5
    a_r5_empty_none: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == '0) |-> (out_empty == !rd_word_vld));

    // R2
    a_r2_bypass_word: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == '0 && rd_word_vld) |-> (out_word == rd_word));

    // R2
    a_r2_bypass_not_stored: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == '0 && rd_word_vld && rcv_pop) |=> (fill_cnt == '0));

    // R8
    a_r8_invalid_no_grow: assert property (@(posedge clk) disable iff (rst)
        !rd_word_vld |=> (fill_cnt <= $past(fill_cnt)));

    // R9
    a_r9_swap_balance: assert property (@(posedge clk) disable iff (rst)
        (rcv_pop && rd_word_vld && fill_cnt != '0) |=> (fill_cnt == $past(fill_cnt)));

endmodule

bind rx_ovf_bypass rx_ovf_bypass_chk #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .THRESH(THRESH),
    .CW    (CW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_word    (rd_word),
    .rd_word_vld(rd_word_vld),
    .rcv_pop    (rcv_pop),
    .out_word   (out_word),
    .out_empty  (out_empty),
    .bk_token   (bk_token),
    .fill_cnt   (fill_cnt),
    .push_en    (push_en),
    .pop_en     (pop_en)
);

// File: tb/rx_ovf_bypass_tb_top.sv
`timescale 1ns/1ps
module rx_ovf_bypass_tb_top;

    localparam int W      = 8;
    localparam int STG    = 4;
    localparam int DEPTH  = 8;
    localparam int THRESH = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] rd_word = '0;
    logic         rd_word_vld = 1'b0;
    logic         rcv_pop = 1'b0;
    logic [W-1:0] out_word;
    logic         out_empty;
    logic         bk_token;

    always #4 clk = ~clk;

    rx_ovf_bypass #(
        .WIDTH      (W),
        .XFER_STAGES(STG),
        .BURST_LEN  (DEPTH),
        .WIRE_CYC   (0)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .rd_word    (rd_word),
        .rd_word_vld(rd_word_vld),
        .rcv_pop    (rcv_pop),
        .out_word   (out_word),
        .out_empty  (out_empty),
        .bk_token   (bk_token)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [W-1:0] q[$];
    logic [W-1:0] sd [STG];
    bit           sv [STG];
    bit           tk [STG];
    logic [W-1:0] tx_seq = '0;
    logic [W-1:0] rx_seq = '0;
    int           cyc = 0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    task automatic step(input bit pop_v, input bit want_send);
        int rp;
        int wp;
        bit e_empty;
        bit e_tok;
        logic [W-1:0] e_data;
        @(negedge clk);
        rp = cyc % STG;
        wp = (cyc + 2) % STG;
        rd_word     = sd[rp];
        rd_word_vld = sv[rp];
        rcv_pop     = pop_v;
        #1;
        e_empty = (q.size() == 0) && !sv[rp];
        chk("R5 empty", W'(out_empty), W'(e_empty));
        e_tok = pop_v ? 1'b1 : (q.size() >= THRESH ? 1'b0 : 1'b1);
        chk(pop_v ? "R6 token" : "R7 token", W'(bk_token), W'(e_tok));
        if (!e_empty) begin
            e_data = (q.size() != 0) ? q[0] : sd[rp];
            chk((q.size() != 0) ? "R4 head" : "R2 bypass", out_word, e_data);
            if (pop_v) begin
                chk("R9 order", out_word, rx_seq);
                rx_seq = rx_seq + 1'b1;
            end
        end
        if (pop_v) begin
            if (q.size() != 0) begin
                void'(q.pop_front());
                if (sv[rp]) q.push_back(sd[rp]);
            end
        end else if (sv[rp]) begin
            q.push_back(sd[rp]);
        end
        if (q.size() > DEPTH) begin
            chk("R3 overflow", W'(q.size()), W'(DEPTH));
        end
        tk[rp] = bk_token;
        if (tk[wp] && want_send) begin
            sd[wp] = tx_seq;
            sv[wp] = 1'b1;
            tx_seq = tx_seq + 1'b1;
        end else begin
            sd[wp] = 8'hEE;
            sv[wp] = 1'b0;
        end
        cyc++;
    endtask

    initial begin
        for (int i = 0; i < STG; i++) begin
            sd[i] = 8'hEE;
            sv[i] = 1'b0;
            tk[i] = 1'b1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 empty after reset", W'(out_empty), W'(1));
        chk("R1 token after reset", W'(bk_token), W'(1));
        // continuous flow
        for (int i = 0; i < 200; i++) step(1'b1, 1'b1);
        // long stalls with full-rate sender
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
            for (int i = 0; i < 15; i++) step(1'b1, 1'b1);
        end
        // random accept, half rate
        for (int i = 0; i < 600; i++) step(1'($urandom_range(0, 1)), 1'b1);
        // mostly stalled receiver
        for (int i = 0; i < 400; i++) step(($urandom_range(0, 9) == 0), 1'b1);
        // sparse sender, random accept
        for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
        // drain
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
        chk("R9 all delivered", rx_seq, tx_seq);
        chk("R5 empty after drain", W'(out_empty), W'(1));
        finished = 1;
    end

    initial begin
        int t;
        t = 0;
        while (!finished && t < 150000) begin
            @(posedge clk);
            t++;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule